// File: doc/BRIEF.md
# Self-correcting Johnson decade counter

This block counts through ten states with a five-stage twisted-ring register. It presents the current state on ten one-hot, active-high lines and on one active-low carry line. The carry line is low for the upper half of the count, so it can feed the rising-edge count input of a following counter. There are two count inputs of opposite sense. One advances the count on its rising edge while the other is low. The other advances the count on its falling edge while the first is high. Either input can therefore serve as the clock while the other serves as an enable.

Both count inputs are sampled on the system clock. An edge is found by comparing the present input with the copy registered on the previous clock, and at most one advance is taken per clock. A master clear input forces state zero at once, independent of the clock, and a count edge that arrives in the clock where the clear is released is ignored. A code outside the ten legal ring patterns lights no decoded line, and the next advance returns the ring to state zero. A test-only load port writes any five-bit code into the ring so that such codes can be injected.

Top module: `johnson_decade_ctr`

## Requirements
- R1: While `rst_n` is low the block is in state 0: `state_hot` = 10'b0000000001 and `carry_n` = 1.
- R2: While `mclr` is high, state 0 is shown without waiting for a clock edge. Count edges and loads in that time have no effect.
- R3: The state advances by one at the clock edge after `cnt_pos` goes from 0 to 1 while `cnt_neg` is 0.
- R4: The state advances by one at the clock edge after `cnt_neg` goes from 1 to 0 while `cnt_pos` is 1.
- R5: No other change of the count inputs moves the state. This covers a rise of `cnt_pos` while `cnt_neg` is 1, a fall of `cnt_neg` while `cnt_pos` is 0, a rise of `cnt_neg`, a fall of `cnt_pos`, and steady levels.
- R6: In state k only `state_hot[k]` is high. Advancing from state 9 gives state 0.
- R7: `carry_n` is 0 in states 5 to 9 and 1 in states 0 to 4.
- R8: With `tload_en` high at a clock edge, the ring takes `tload_val`, and a load wins over a count advance in the same clock. In ring code bit 0 is the first stage. State k for k ≤ 5 has bits k-1..0 set and the others clear. State k for k ≥ 6 has bits 4..k-5 set and the others clear.
- R9: For any of the 22 five-bit codes that are not legal ring codes, all `state_hot` lines are low.
- R10: From an illegal code, the first advance gives state 0, well inside the limit of eleven advances. Later advances follow the normal sequence.
- R11: An edge on the count inputs in the clock where `mclr` is released causes no advance, and the next edge counts normally.
- R12: A rise of `cnt_pos` together with a fall of `cnt_neg` in the same clock advances the state by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; count inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| mclr | input | 1 | Asynchronous active-high master clear to state 0 |
| cnt_pos | input | 1 | Count input acting on its rising edge, enabled by `cnt_neg` low |
| cnt_neg | input | 1 | Count input acting on its falling edge, enabled by `cnt_pos` high |
| tload_en | input | 1 | Test load strobe, synchronous |
| tload_val | input | 5 | Test load ring code |
| state_hot | output | 10 | One-hot decoded state, bit k high in state k |
| carry_n | output | 1 | Active-low carry, low in states 5 to 9 |

## Verification
A vector table drives the two count inputs through every pairing of edges and levels. These include a rising edge with the enable high and with it low, a falling edge with the enable high and with it low, opposite edges in the same clock, and edges that only move the enable. This separates the two counting paths from each other and from the combinations that must be blocked. Directed tests load every legal code, walk the wrap from 9 to 0, and cross the carry boundary. They also inject all 22 illegal codes to observe the blank decode and the return to state 0, and they time a count edge against the release of the master clear.

// File: rtl/jdc_pkg.sv
package jdc_pkg;
  // Source of the ring's next value
  typedef enum logic [2:0] {
    NXT_KEEP  = 3'd0,
    NXT_STEP  = 3'd1,
    NXT_FIX   = 3'd2,
    NXT_LOAD  = 3'd3,
    NXT_CLEAR = 3'd4
  } jdc_nxt_e;
endpackage

// File: rtl/jdc_rst_sync.sv
module jdc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/jdc_edge.sv
module jdc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_pos,
  input  logic cnt_neg,
  output logic advance
);
  logic pos_q;
  logic neg_q;
  logic pos_rise;
  logic neg_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 1'b0;
      neg_q <= 1'b0;
    end else begin
      pos_q <= cnt_pos;
      neg_q <= cnt_neg;
    end
  end

  // A rising edge counts only while the other input is low.
  // A falling edge counts only while the other input is high.
  assign pos_rise = cnt_pos & ~pos_q & ~cnt_neg;
  assign neg_fall = ~cnt_neg & neg_q & cnt_pos;
  // Both qualifying edges in one clock still give a single advance.
  assign advance  = pos_rise | neg_fall;
endmodule

// File: rtl/jdc_ring.sv
module jdc_ring
  import jdc_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              advance,
  input  logic              load_en,
  input  logic [STAGES-1:0] load_val,
  output logic [STAGES-1:0] ring,
  output logic              legal,
  output logic              clr_hold
);
  localparam int NDIFF = STAGES - 1;

  logic [STAGES-1:0] ring_q;
  logic [STAGES-1:0] ring_nxt;
  logic [NDIFF-1:0]  bit_diff;
  logic              hold_q;
  jdc_nxt_e          nxt_sel;

  // A legal twisted-ring code has at most one boundary between adjacent stages.
  assign bit_diff = ring_q[STAGES-1:1] ^ ring_q[STAGES-2:0];
  assign legal    = ((bit_diff & (bit_diff - 1'b1)) == '0);

  // The clear release is registered, so the first clock after it still forces zero.
  always_ff @(posedge clk or negedge rst_n or posedge mclr) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
    end else if (mclr) begin
      hold_q <= 1'b1;
    end else begin
      hold_q <= 1'b0;
    end
  end

  always_comb begin
    if (hold_q)       nxt_sel = NXT_CLEAR;
    else if (load_en) nxt_sel = NXT_LOAD;
    else if (advance) nxt_sel = legal ? NXT_STEP : NXT_FIX;
    else              nxt_sel = NXT_KEEP;
  end

  always_comb begin
    case (nxt_sel)
      NXT_CLEAR: ring_nxt = '0;
      NXT_LOAD:  ring_nxt = load_val;
      NXT_STEP:  ring_nxt = {ring_q[STAGES-2:0], ~ring_q[STAGES-1]};
      NXT_FIX:   ring_nxt = '0;
      default:   ring_nxt = ring_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n or posedge mclr) begin
    if (!rst_n) begin
      ring_q <= '0;
    end else if (mclr) begin
      ring_q <= '0;
    end else begin
      ring_q <= ring_nxt;
    end
  end

  assign ring     = ring_q;
  assign clr_hold = hold_q;
endmodule

// File: rtl/jdc_decode.sv
module jdc_decode #(
  parameter int STAGES = 5,
  localparam int NSTATE = 2 * STAGES
) (
  input  logic [STAGES-1:0] ring,
  input  logic              legal,
  output logic [NSTATE-1:0] state_hot,
  output logic              carry_n
);
  logic [NSTATE-1:0] raw;

  // Each state is recognised from one pair of neighbouring stages.
  for (genvar k = 0; k < NSTATE; k++) begin : g_dec
    if (k == 0) begin : g_first
      assign raw[k] = ~ring[STAGES-1] & ~ring[0];
    end else if (k < STAGES) begin : g_fill
      assign raw[k] = ring[k-1] & ~ring[k];
    end else if (k == STAGES) begin : g_full
      assign raw[k] = ring[STAGES-1] & ring[0];
    end else begin : g_drain
      assign raw[k] = ~ring[k-STAGES-1] & ring[k-STAGES];
    end
  end

  assign state_hot = legal ? raw : '0;
  assign carry_n   = ~ring[STAGES-1];
endmodule

// File: rtl/johnson_decade_ctr.sv
module johnson_decade_ctr #(
  parameter int STAGES = 5,
  localparam int NSTATE = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              cnt_pos,
  input  logic              cnt_neg,
  input  logic              tload_en,
  input  logic [STAGES-1:0] tload_val,
  output logic [NSTATE-1:0] state_hot,
  output logic              carry_n
);
  logic              rst_int_n;
  logic              advance;
  logic [STAGES-1:0] ring_q;
  logic              legal;
  logic              clr_hold;

  jdc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  jdc_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cnt_pos (cnt_pos),
    .cnt_neg (cnt_neg),
    .advance (advance)
  );

  jdc_ring #(.STAGES(STAGES)) u_ring (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .mclr     (mclr),
    .advance  (advance),
    .load_en  (tload_en),
    .load_val (tload_val),
    .ring     (ring_q),
    .legal    (legal),
    .clr_hold (clr_hold)
  );

  jdc_decode #(.STAGES(STAGES)) u_dec (
    .ring      (ring_q),
    .legal     (legal),
    .state_hot (state_hot),
    .carry_n   (carry_n)
  );
endmodule

// File: rtl/jdc_checker.sv
module jdc_checker #(
  parameter int STAGES = 5,
  localparam int NSTATE = 2 * STAGES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mclr,
  input logic              cnt_pos,
  input logic              cnt_neg,
  input logic              tload_en,
  input logic [STAGES-1:0] tload_val,
  input logic [NSTATE-1:0] state_hot,
  input logic              carry_n,
  input logic [STAGES-1:0] ring,
  input logic              clr_hold
);
  localparam logic [NSTATE-1:0] ZERO_HOT = NSTATE'(1);

  // R2
  mclr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |-> (state_hot == ZERO_HOT && carry_n));

  // R6
  one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(state_hot));

  // R7
  carry_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|state_hot) |-> (carry_n == ~|state_hot[NSTATE-1:STAGES]));

  // R5
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    (!tload_en && !clr_hold && $stable(cnt_pos) && $stable(cnt_neg)) |=> $stable(ring));

  // R3
  rise_step_chk: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    ($rose(cnt_pos) && !cnt_neg && !tload_en && !clr_hold && (|state_hot))
    |=> state_hot == {$past(state_hot[NSTATE-2:0]), $past(state_hot[NSTATE-1])});

  // R8
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    (tload_en && !clr_hold) |=> ring == $past(tload_val));

  // R10
  fix_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || mclr)
    (state_hot == '0 && !tload_en && !clr_hold && $rose(cnt_pos) && !cnt_neg)
    |=> ring == '0);
endmodule

bind johnson_decade_ctr jdc_checker #(.STAGES(STAGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .mclr      (mclr),
  .cnt_pos   (cnt_pos),
  .cnt_neg   (cnt_neg),
  .tload_en  (tload_en),
  .tload_val (tload_val),
  .state_hot (state_hot),
  .carry_n   (carry_n),
  .ring      (ring_q),
  .clr_hold  (clr_hold)
);

// File: tb/tb_johnson_decade_ctr.sv
`timescale 1ns/1ps
module tb_johnson_decade_ctr;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mclr;
  logic       cnt_pos;
  logic       cnt_neg;
  logic       tload_en;
  logic [4:0] tload_val;
  logic [9:0] state_hot;
  logic       carry_n;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  johnson_decade_ctr dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mclr      (mclr),
    .cnt_pos   (cnt_pos),
    .cnt_neg   (cnt_neg),
    .tload_en  (tload_en),
    .tload_val (tload_val),
    .state_hot (state_hot),
    .carry_n   (carry_n)
  );

  // Vector: {requirement[3:0], cnt_pos, cnt_neg, expected state[3:0]}
  // Rows exercise R3, R4, R5 and R12.
  localparam logic [9:0] VEC [0:17] = '{
    {4'd3,  1'b1, 1'b0, 4'd1},
    {4'd5,  1'b0, 1'b0, 4'd1},
    {4'd5,  1'b0, 1'b1, 4'd1},
    {4'd5,  1'b1, 1'b1, 4'd1},
    {4'd4,  1'b1, 1'b0, 4'd2},
    {4'd5,  1'b1, 1'b1, 4'd2},
    {4'd5,  1'b0, 1'b1, 4'd2},
    {4'd5,  1'b0, 1'b0, 4'd2},
    {4'd3,  1'b1, 1'b0, 4'd3},
    {4'd5,  1'b0, 1'b1, 4'd3},
    {4'd12, 1'b1, 1'b0, 4'd4},
    {4'd5,  1'b0, 1'b0, 4'd4},
    {4'd3,  1'b1, 1'b0, 4'd5},
    {4'd5,  1'b0, 1'b0, 4'd5},
    {4'd3,  1'b1, 1'b0, 4'd6},
    {4'd5,  1'b1, 1'b1, 4'd6},
    {4'd4,  1'b1, 1'b0, 4'd7},
    {4'd5,  1'b0, 1'b0, 4'd7}
  };

  function automatic logic [4:0] code_of(int k);
    if (k <= 5) return 5'((1 << k) - 1);
    return 5'b11111 & ~5'((1 << (k - 5)) - 1);
  endfunction

  function automatic bit is_legal(logic [4:0] c);
    for (int k = 0; k < 10; k++) if (code_of(k) == c) return 1'b1;
    return 1'b0;
  endfunction

  // exp < 0 means an illegal code: no decoded line may be high
  task automatic check_state(int exp, string req);
    logic [9:0] eh;
    tests++;
    if (exp < 0) begin
      if (state_hot !== 10'b0) begin
        fails++;
        $display("FAIL %s: state_hot=%b expected %b", req, state_hot, 10'b0);
      end
    end else begin
      eh = 10'(1 << exp);
      if (state_hot !== eh || carry_n !== (exp < 5)) begin
        fails++;
        $display("FAIL %s: state_hot=%b carry_n=%b expected %b carry_n=%b",
                 req, state_hot, carry_n, eh, (exp < 5));
      end
    end
  endtask

  task automatic adv();
    cnt_pos = 1'b1;
    @(negedge clk);
    cnt_pos = 1'b0;
    @(negedge clk);
  endtask

  task automatic load(logic [4:0] c);
    tload_en  = 1'b1;
    tload_val = c;
    @(negedge clk);
    tload_en  = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mclr = 1'b0; cnt_pos = 1'b0; cnt_neg = 1'b0;
    tload_en = 1'b0; tload_val = '0;
    #9;
    check_state(0, "R1 during reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_state(0, "R1 after reset");

    // Table walk: drive at a falling edge, sample at the next falling edge
    for (int i = 0; i < 18; i++) begin
      cnt_pos = VEC[i][5];
      cnt_neg = VEC[i][4];
      @(negedge clk);
      check_state(int'(VEC[i][3:0]), $sformatf("R%0d table row %0d", VEC[i][9:6], i));
    end

    // R6 and R7: across the carry boundary and the wrap
    cnt_pos = 1'b0; cnt_neg = 1'b0;
    @(negedge clk);
    adv(); check_state(8, "R7 state 8");
    adv(); check_state(9, "R7 state 9");
    adv(); check_state(0, "R6 wrap to 0");

    // R8: every legal code loads to its state
    for (int k = 0; k < 10; k++) begin
      load(code_of(k));
      check_state(k, "R8 legal load");
    end

    // R8: a load wins over a count edge in the same clock
    load(code_of(2));
    tload_en = 1'b1; tload_val = code_of(8); cnt_pos = 1'b1;
    @(negedge clk);
    tload_en = 1'b0; cnt_pos = 1'b0;
    check_state(8, "R8 load over advance");
    @(negedge clk);
    check_state(8, "R8 hold after load");

    // R9 and R10: all illegal codes
    for (int c = 0; c < 32; c++) begin
      if (!is_legal(5'(c))) begin
        int n;
        load(5'(c));
        check_state(-1, "R9 illegal blank");
        n = 0;
        while (state_hot == 10'b0 && n < 12) begin
          adv();
          n++;
        end
        tests++;
        if (n > 11) begin
          fails++;
          $display("FAIL R10: code %b took %0d advances, expected <= 11", 5'(c), n);
        end
        check_state(0, "R10 recovered to 0");
        adv();
        check_state(1, "R10 normal after recovery");
      end
    end

    // R2: asynchronous clear overrides count and load
    load(code_of(3));
    #1 mclr = 1'b1;
    #0.5;
    check_state(0, "R2 immediate clear");
    @(negedge clk);
    adv();
    load(code_of(6));
    check_state(0, "R2 count and load blocked");

    // R11: edge in the release clock is ignored
    mclr = 1'b0; cnt_pos = 1'b1;
    @(negedge clk);
    check_state(0, "R11 edge at release ignored");
    cnt_pos = 1'b0;
    @(negedge clk);
    adv();
    check_state(1, "R11 next edge counts");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule